// File: doc/BRIEF.md
# Removable-Media Slot Interrupt Controller

This block watches a removable-media slot and tells the host about card insertion and removal. It takes the raw card-present, write-protect and media-busy lines, brings them into the clock domain, filters the present line with a settle counter, and turns each accepted change of presence into an event in an interrupt status register. Software arms the events through an interrupt enable register and clears them by writing ones to the status register.

Only the event that can happen next can be armed: with a card in the slot, only removal can be enabled; with the slot empty, only insertion. Every accepted event disarms both event enables, so software has to re-arm once the slot has settled. The card interrupt shares one output line with an external DMA request, and a source code output always names the card as the cause when both are pending.

Top module: `cd_irq_ctrl`

## Requirements
- R1: The present bit (card_status bit 0) changes only after the synchronised present input has differed from it for SETTLE_CYCLES consecutive clocks. With the raw input changed just before clock edge 1, the new value is visible after edge SETTLE_CYCLES+2 and not before. A shorter pulse has no effect.
- R2: card_status bit 1 is write-protect, bit 2 is busy, bit 3 is ready (the inverse of busy). Bits 1 and 2 follow their raw inputs through two flip-flops.
- R3: A write with wr_addr 0 loads the enable register: data bit 2 is the global enable and is stored as written. Data bit 0 (insert enable) is stored only while the slot is empty, and data bit 1 (remove enable) only while a card is present. Otherwise the stored bit is 0.
- R4: A rise of the filtered present bit sets irq_status bit 0 (inserted), and a fall sets bit 1 (removed). This happens whether or not the enables are set.
- R5: A write with wr_addr 1 clears each irq_status bit whose data bit is 1. If an event sets a bit in the same cycle that the write clears it, the bit stays set.
- R6: Every accepted insert or remove event clears the insert and remove enables. The global enable keeps its value.
- R7: The card interrupt is pending for an event whose enable was set when the event occurred. It stays pending until that status bit is cleared, and it drives the interrupt only while the global enable is 1. An event whose enable was clear never raises the interrupt.
- R8: irq is the OR of the card interrupt and dma_req. irq_src is 2'b01 while the card interrupt is active, 2'b10 when only dma_req is active, and 2'b00 otherwise.
- R9: After reset the enable, status and source outputs are zero, the present bit is 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| present_raw | input | 1 | Unsynchronised card-present line |
| wprot_raw | input | 1 | Unsynchronised write-protect line |
| busy_raw | input | 1 | Unsynchronised media-busy line |
| dma_req | input | 1 | DMA interrupt request sharing the output line |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 1 | 0 = enable register, 1 = status clear |
| wr_data | input | 3 | Write data |
| card_status | output | 4 | {ready, busy, write-protect, present} |
| irq_enable | output | 3 | {global, remove, insert} enables |
| irq_status | output | 2 | {removed, inserted} event flags |
| irq | output | 1 | Shared interrupt line |
| irq_src | output | 2 | Cause of irq, card first |

## Verification
The hardest case to reach from the ports is a status-clear write that lands on the same clock edge as the debounce commit that sets the bit. That edge is fixed only by the sync and settle latency. The stimulus changes the present input at a known falling edge, counts SETTLE_CYCLES+1 further falling edges, and then issues the clear. It checks that the present bit is still the old value just before that edge and that the status bit survives it. Random sequences of slot changes, enable and clear writes, and DMA toggles then run against a transaction-level model of the arming rules.

// File: rtl/cd_irq_pkg.sv
package cd_irq_pkg;
  localparam int unsigned EN_INS = 0;
  localparam int unsigned EN_REM = 1;
  localparam int unsigned EN_GLB = 2;
  localparam int unsigned ST_INS = 0;
  localparam int unsigned ST_REM = 1;
  localparam logic ADDR_EN = 1'b0;
  localparam logic ADDR_ST = 1'b1;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_CARD = 2'b01,
    SRC_DMA  = 2'b10
  } irq_src_e;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differ, commit;

  assign differ = sample_i ^ level_q;
  assign commit = differ && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!differ || commit) begin
      cnt_q <= '0;
      if (commit) level_q <= sample_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
  assign rise_o  = commit & sample_i;
  assign fall_o  = commit & ~sample_i;
endmodule

// File: rtl/cd_irq_regs.sv
module cd_irq_regs
  import cd_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present_i,
  input  logic       ins_edge_i,
  input  logic       rem_edge_i,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [2:0] wr_data,
  output logic [2:0] enable_o,
  output logic [1:0] status_o,
  output logic       card_irq_o
);
  logic [2:0] ie_q;
  logic [1:0] st_q, pend_q;
  logic [1:0] evt, clr;
  logic       en_wr;

  assign evt   = {rem_edge_i, ins_edge_i};
  assign en_wr = wr_en && (wr_addr == ADDR_EN);
  assign clr   = (wr_en && (wr_addr == ADDR_ST)) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      st_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) ie_q[EN_GLB] <= wr_data[EN_GLB];
      if (|evt) begin
        ie_q[EN_INS] <= 1'b0;
        ie_q[EN_REM] <= 1'b0;
      end else if (en_wr) begin
        ie_q[EN_INS] <= wr_data[EN_INS] & ~present_i;
        ie_q[EN_REM] <= wr_data[EN_REM] & present_i;
      end
      st_q   <= (st_q & ~clr) | evt;
      pend_q <= (pend_q & ~clr) | (evt & ie_q[1:0]);
    end
  end

  assign enable_o   = ie_q;
  assign status_o   = st_q;
  assign card_irq_o = ie_q[EN_GLB] & |pend_q;

  assert_arm_ins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q[EN_INS] |-> !present_i);
  assert_arm_rem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q[EN_REM] |-> present_i);
  assert_evt_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_edge_i || rem_edge_i) && !en_wr) |=>
      (!ie_q[EN_INS] && !ie_q[EN_REM] && $stable(ie_q[EN_GLB])));
  assert_ins_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_edge_i |=> st_q[ST_INS]);
  assert_rem_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_edge_i |=> st_q[ST_REM]);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq_o |-> (ie_q[EN_GLB] && |st_q));
endmodule

// File: rtl/cd_irq_ctrl.sv
module cd_irq_ctrl
  import cd_irq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present_raw,
  input  logic       wprot_raw,
  input  logic       busy_raw,
  input  logic       dma_req,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [2:0] wr_data,
  output logic [3:0] card_status,
  output logic [2:0] irq_enable,
  output logic [1:0] irq_status,
  output logic       irq,
  output logic [1:0] irq_src
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] sync_v;
  logic             present, ins_edge, rem_edge, card_irq;
  irq_src_e         src;

  cd_sync #(.WIDTH(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({busy_raw, wprot_raw, present_raw}),
    .sync_o(sync_v)
  );

  cd_debounce #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_i(sync_v[0]),
    .level_o(present), .rise_o(ins_edge), .fall_o(rem_edge)
  );

  cd_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .present_i(present),
    .ins_edge_i(ins_edge), .rem_edge_i(rem_edge),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable_o(irq_enable), .status_o(irq_status), .card_irq_o(card_irq)
  );

  always_comb begin
    if (card_irq)     src = SRC_CARD;
    else if (dma_req) src = SRC_DMA;
    else              src = SRC_NONE;
  end

  assign card_status = {~sync_v[2], sync_v[2], sync_v[1], present};
  assign irq         = card_irq | dma_req;
  assign irq_src     = src;

  assert_card_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq |-> (irq_src == SRC_CARD && irq));
  assert_dma_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !card_irq) |-> irq_src == SRC_DMA);
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    card_status[3] != card_status[2]);
endmodule

// File: tb/cd_irq_ctrl_test.sv
module cd_irq_ctrl_test;
  localparam int unsigned SETTLE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic present_raw = 0, wprot_raw = 0, busy_raw = 0, dma_req = 0;
  logic wr_en = 0, wr_addr = 0;
  logic [2:0] wr_data = '0;
  logic [3:0] card_status;
  logic [2:0] irq_enable;
  logic [1:0] irq_status, irq_src;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic       m_pres = 0, m_dma = 0;
  logic [2:0] m_ie = '0;
  logic [1:0] m_st = '0, m_pend = '0;

  always #4 clk = ~clk;

  cd_irq_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .present_raw(present_raw), .wprot_raw(wprot_raw),
    .busy_raw(busy_raw), .dma_req(dma_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .card_status(card_status), .irq_enable(irq_enable),
    .irq_status(irq_status), .irq(irq), .irq_src(irq_src)
  );

  function automatic logic exp_card();
    return m_ie[2] & |m_pend;
  endfunction
  function automatic logic [1:0] exp_src();
    return exp_card() ? 2'b01 : (m_dma ? 2'b10 : 2'b00);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " present"}, 8'(card_status[0]), 8'(m_pres));
    chk({req, " enable"}, 8'(irq_enable), 8'(m_ie));
    chk({req, " status"}, 8'(irq_status), 8'(m_st));
    chk({req, " irq"}, 8'(irq), 8'(exp_card() | m_dma));
    chk({req, " src"}, 8'(irq_src), 8'(exp_src()));
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 1'b0) m_ie = {d[2], d[1] & m_pres, d[0] & ~m_pres};
    else begin m_st &= ~d[1:0]; m_pend &= ~d[1:0]; end
  endtask

  task automatic model_evt(input logic p);
    if (p != m_pres) begin
      if (p) begin m_st[0] = 1; m_pend[0] |= m_ie[0]; end
      else   begin m_st[1] = 1; m_pend[1] |= m_ie[1]; end
      m_ie[1:0] = 2'b00;
      m_pres = p;
    end
  endtask

  task automatic move(input logic p);
    present_raw = p;
    repeat (SETTLE + 6) @(negedge clk);
    model_evt(p);
  endtask

  task automatic set_dma(input logic v);
    dma_req = v; m_dma = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 status", 8'(card_status), 8'h8);
    chk_all("R9");

    // R2 write-protect, busy, ready
    wprot_raw = 1; busy_raw = 1;
    repeat (3) @(negedge clk);
    chk("R2 wp busy", 8'(card_status), 8'h6);
    busy_raw = 0;
    repeat (3) @(negedge clk);
    chk("R2 ready", 8'(card_status), 8'hA);

    // R3 arm with slot empty: only insert sticks
    wr(1'b0, 3'b111);
    chk("R3 empty arm", 8'(irq_enable), 8'h5);

    // R1 short pulse ignored
    present_raw = 1;
    repeat (SETTLE / 2) @(negedge clk);
    present_raw = 0;
    repeat (SETTLE + 6) @(negedge clk);
    chk("R1 glitch present", 8'(card_status[0]), 8'h0);
    chk("R1 glitch status", 8'(irq_status), 8'h0);

    // R1 exact latency and R5 set wins over simultaneous clear
    present_raw = 1;
    repeat (SETTLE + 1) @(negedge clk);
    chk("R1 not yet", 8'(card_status[0]), 8'h0);
    wr_en = 1; wr_addr = 1; wr_data = 3'b001;
    @(negedge clk);
    wr_en = 0;
    model_evt(1'b1);
    chk("R1 committed", 8'(card_status[0]), 8'h1);
    chk("R5 set wins", 8'(irq_status), 8'h1);
    chk("R6 disarm", 8'(irq_enable), 8'h4);
    chk("R7 irq raised", 8'(irq), 8'h1);
    chk_all("R7");

    // R8 priority with DMA
    set_dma(1);
    chk("R8 card first", 8'(irq_src), 8'h1);
    wr(1'b1, 3'b001);
    chk("R8 dma only", 8'(irq_src), 8'h2);
    chk("R5 cleared", 8'(irq_status), 8'h0);
    chk_all("R8");

    // R3 arm with card present
    wr(1'b0, 3'b111);
    chk("R3 present arm", 8'(irq_enable), 8'h6);
    wr(1'b0, 3'b010);
    set_dma(0);
    move(1'b0);
    chk("R7 masked by global", 8'(irq), 8'h0);
    chk("R4 removed", 8'(irq_status), 8'h2);
    wr(1'b0, 3'b100);
    chk("R7 unmasked", 8'(irq), 8'h1);
    wr(1'b1, 3'b010);
    chk("R7 cleared", 8'(irq), 8'h0);

    // R4 event with enable off sets status only
    move(1'b1);
    chk("R4 status no en", 8'(irq_status), 8'h1);
    chk("R7 no irq", 8'(irq), 8'h0);
    chk_all("R4");

    // random mix
    for (int i = 0; i < 80; i++) begin
      case ($urandom_range(0, 3))
        0: begin move(1'($urandom_range(0, 1))); chk_all("R4 R6 rnd"); end
        1: begin wr(1'b0, 3'($urandom_range(0, 7))); chk_all("R3 rnd"); end
        2: begin wr(1'b1, 3'($urandom_range(0, 3))); chk_all("R5 R7 rnd"); end
        default: begin set_dma(1'($urandom_range(0, 1))); chk_all("R8 rnd"); end
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule